// File: doc/BRIEF.md
# Conditional Token Forward-or-Discard Element

This block is a clocked model of a steering stage in a token-based data path. A data token, with a payload of parameter width, arrives on the outer side. There it is paired with a control token that comes in on a dual-rail code. A control value of one moves the token to the inner side, which downstream observes. The outer side then empties. A control value of zero acknowledges the token and drops it. No inner token is ever produced.

Upstream logic sees only the outer marking, and downstream logic sees only the inner marking. The control side takes a token only after a data token is present, and it gives the token back only once the outer side is empty again. Each rule advances by at most one step per clock edge. This keeps every transition visible and ordered for the surrounding model.

Top module: `fwd_or_drop`

## Requirements
- R1: After reset, outer_en, outer_marked, ctl_marked, inner_en, inner_marked, ctl_err and inner_data are all zero.
- R2: outer_en equals (up_marked AND up_eval) as sampled at the previous rising edge.
- R3: outer_marked rises, and up_data is captured as the payload, only at an edge where outer_en=1, up_marked=1, and both inner_marked=0 and ctl_marked=0. Later changes of up_data do not alter the captured payload.
- R4: outer_marked falls only at an edge where outer_en=0, up_marked=0, and either inner_marked=1 or the held control value is zero. While up_marked stays high, outer_marked stays set.
- R5: ctl_rail uses bit 0 as the one-rail (value 1, forward) and bit 1 as the zero-rail (value 0, discard); 00 means no token. The control side takes a token only at an edge where outer_marked=1. It releases the token only at an edge where outer_marked=0.
- R6: inner_en equals (outer_marked AND held control value is 1) from the previous edge. inner_marked rises only at an edge where inner_en=1 and dn_marked=0, and inner_data then takes the captured payload.
- R7: A marked inner side clears at an edge where inner_en=0 and dn_marked=1.
- R8: With a held control value of 0, inner_en and inner_marked stay 0, and inner_data keeps its earlier value.
- R9: The rail code 11 is never accepted. ctl_err is 1 exactly one edge after ctl_rail=11 was sampled, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_marked | input | 1 | Every upstream register holds a token |
| up_eval | input | 1 | Every upstream logic node is evaluated |
| up_data | input | W | Payload offered from upstream |
| ctl_rail | input | 2 | Dual-rail control token (bit0 = value 1, bit1 = value 0) |
| dn_marked | input | 1 | Downstream registers hold a token |
| outer_en | output | 1 | Outer side enabled |
| outer_marked | output | 1 | Outer side holds a token (seen by upstream) |
| ctl_marked | output | 1 | Control side holds a token |
| inner_en | output | 1 | Inner side enabled |
| inner_marked | output | 1 | Inner side holds a token (seen by downstream) |
| inner_data | output | W | Payload of the inner side |
| ctl_err | output | 1 | Illegal rail code 11 seen at the last edge |

## Verification
Every result is due one rising edge after its cause:
- outer_en one edge after the upstream inputs change;
- the outer token on the next edge;
- the control token one edge after the outer token;
- inner_en one edge after the control token;
- the inner token one edge after inner_en, as long as dn_marked is low.

An outer token is released two edges after up_marked drops: one edge to disable the outer side, one to empty it. The control side releases on the edge after that. The bench drives inputs on falling edges and samples on the falling edge after each rising edge. It therefore checks each output exactly at the edge where the rule chain above puts the change. Stall windows on dn_marked and held upstream inputs are checked at every edge to show that nothing moves early.

// File: rtl/fod_pkg.sv
package fod_pkg;
  typedef enum logic [1:0] {
    CT_NONE = 2'b00,
    CT_ONE  = 2'b01,
    CT_ZERO = 2'b10,
    CT_BAD  = 2'b11
  } ctl_code_e;

  function automatic logic has_token(input logic [1:0] r);
    return (r == CT_ONE) || (r == CT_ZERO);
  endfunction

  function automatic logic is_fwd(input logic [1:0] r);
    return r == CT_ONE;
  endfunction

  function automatic logic is_drop(input logic [1:0] r);
    return r == CT_ZERO;
  endfunction

  function automatic logic is_bad(input logic [1:0] r);
    return r == CT_BAD;
  endfunction
endpackage

// File: rtl/fod_ctl.sv
module fod_ctl
  import fod_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rail,
  input  logic       outer_marked,
  output logic       marked,
  output logic       fwd,
  output logic       drop,
  output logic       err
);
  logic [1:0] held_q;
  logic       take_ev, give_ev;

  assign take_ev = !has_token(held_q) && outer_marked && has_token(rail);
  assign give_ev = has_token(held_q) && !outer_marked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= CT_NONE;
      err    <= 1'b0;
    end else begin
      err <= is_bad(rail);
      if (take_ev)      held_q <= rail;
      else if (give_ev) held_q <= CT_NONE;
    end
  end

  assign marked = has_token(held_q);
  assign fwd    = is_fwd(held_q);
  assign drop   = is_drop(held_q);

  a_r5_take_needs_outer: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(marked) |-> $past(outer_marked));
  a_r5_give_needs_empty: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(marked) |-> $past(!outer_marked));
  a_r9_bad_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !$rose(marked));
  a_r9_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(rail == CT_BAD));
endmodule

// File: rtl/fod_outer.sv
module fod_outer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_marked,
  input  logic         up_eval,
  input  logic [W-1:0] up_data,
  input  logic         inner_marked,
  input  logic         ctl_marked,
  input  logic         ctl_drop,
  output logic         en,
  output logic         marked,
  output logic [W-1:0] payload
);
  logic take_ev, leave_ev;

  assign take_ev  = en && !marked && !inner_marked && !ctl_marked && up_marked;
  assign leave_ev = marked && !en && !up_marked && (inner_marked || ctl_drop);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en      <= 1'b0;
      marked  <= 1'b0;
      payload <= '0;
    end else begin
      en <= up_marked && up_eval;
      if (take_ev) begin
        marked  <= 1'b1;
        payload <= up_data;
      end else if (leave_ev) begin
        marked  <= 1'b0;
      end
    end
  end

  a_r3_take_rule: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(marked) |-> $past(en && up_marked && !inner_marked && !ctl_marked));
  a_r4_leave_rule: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(marked) |-> $past(!en && !up_marked && (inner_marked || ctl_drop)));
  a_r3_payload_held: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(marked) && marked) |-> $stable(payload));
endmodule

// File: rtl/fod_inner.sv
module fod_inner #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         outer_marked,
  input  logic         ctl_fwd,
  input  logic         dn_marked,
  input  logic [W-1:0] payload,
  output logic         en,
  output logic         marked,
  output logic [W-1:0] data
);
  logic fill_ev, drain_ev;

  assign fill_ev  = en && !marked && !dn_marked;
  assign drain_ev = marked && !en && dn_marked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en     <= 1'b0;
      marked <= 1'b0;
      data   <= '0;
    end else begin
      en <= outer_marked && ctl_fwd;
      if (fill_ev) begin
        marked <= 1'b1;
        data   <= payload;
      end else if (drain_ev) begin
        marked <= 1'b0;
      end
    end
  end

  a_r6_fill_rule: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(marked) |-> $past(en && !dn_marked));
  a_r7_drain_rule: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(marked) |-> $past(!en && dn_marked));
  a_r8_data_only_on_fill: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(marked) |-> $stable(data));
endmodule

// File: rtl/fwd_or_drop.sv
module fwd_or_drop #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_marked,
  input  logic         up_eval,
  input  logic [W-1:0] up_data,
  input  logic [1:0]   ctl_rail,
  input  logic         dn_marked,
  output logic         outer_en,
  output logic         outer_marked,
  output logic         ctl_marked,
  output logic         inner_en,
  output logic         inner_marked,
  output logic [W-1:0] inner_data,
  output logic         ctl_err
);
  logic         ctl_fwd, ctl_drop;
  logic [W-1:0] payload;

  fod_outer #(.W(W)) u_outer (
    .clk(clk), .rst_n(rst_n), .up_marked(up_marked), .up_eval(up_eval),
    .up_data(up_data), .inner_marked(inner_marked), .ctl_marked(ctl_marked),
    .ctl_drop(ctl_drop), .en(outer_en), .marked(outer_marked), .payload(payload)
  );

  fod_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .rail(ctl_rail), .outer_marked(outer_marked),
    .marked(ctl_marked), .fwd(ctl_fwd), .drop(ctl_drop), .err(ctl_err)
  );

  fod_inner #(.W(W)) u_inner (
    .clk(clk), .rst_n(rst_n), .outer_marked(outer_marked), .ctl_fwd(ctl_fwd),
    .dn_marked(dn_marked), .payload(payload), .en(inner_en),
    .marked(inner_marked), .data(inner_data)
  );

  a_r8_drop_no_inner: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_drop |-> (!inner_marked && !inner_en));
  a_r6_en_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inner_en) |-> $past(outer_marked && ctl_fwd));
endmodule

// File: tb/sim_fwd_or_drop.sv
`timescale 1ns/1ps
module sim_fwd_or_drop;
  localparam int W = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up_marked = 0, up_eval = 0, dn_marked = 0;
  logic [W-1:0] up_data = '0;
  logic [1:0] ctl_rail = 2'b00;
  logic outer_en, outer_marked, ctl_marked, inner_en, inner_marked, ctl_err;
  logic [W-1:0] inner_data;
  int total = 0, bad = 0;
  logic [W-1:0] last_inner = '0;

  always #2.5 clk = ~clk;

  fwd_or_drop #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .up_marked(up_marked), .up_eval(up_eval),
    .up_data(up_data), .ctl_rail(ctl_rail), .dn_marked(dn_marked),
    .outer_en(outer_en), .outer_marked(outer_marked), .ctl_marked(ctl_marked),
    .inner_en(inner_en), .inner_marked(inner_marked), .inner_data(inner_data),
    .ctl_err(ctl_err)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [W-1:0] d, input bit fwd, input int stall);
    up_marked = 1; up_eval = 1; up_data = d;
    ctl_rail = fwd ? 2'b01 : 2'b10;
    dn_marked = (stall > 0);
    step();
    chk("R2 outer_en", outer_en, 1);
    chk("R5 no ctl before token", ctl_marked, 0);
    step();
    chk("R3 outer token", outer_marked, 1);
    chk("R5 ctl waits for token", ctl_marked, 0);
    step();
    chk("R5 ctl taken", ctl_marked, 1);
    up_data = ~d;
    if (fwd) begin
      ctl_rail = 2'b00;
      step();
      chk("R6 inner_en", inner_en, 1);
      for (int i = 0; i < stall; i++) begin
        step();
        chk("R6 inner stalled by dn_marked", inner_marked, 0);
      end
      dn_marked = 0;
      step();
      chk("R6 inner marked", inner_marked, 1);
      chk("R3 R6 inner payload", inner_data, d);
      step();
      chk("R4 outer held while up_marked", outer_marked, 1);
      up_marked = 0; up_eval = 0;
      step();
      chk("R2 outer_en off", outer_en, 0);
      chk("R4 outer still held", outer_marked, 1);
      step();
      chk("R4 outer empties", outer_marked, 0);
      chk("R5 ctl held one more edge", ctl_marked, 1);
      step();
      chk("R5 ctl released", ctl_marked, 0);
      chk("R6 inner_en off", inner_en, 0);
      chk("R7 inner kept", inner_marked, 1);
      dn_marked = 1;
      step();
      chk("R7 inner drains", inner_marked, 0);
      dn_marked = 0;
      last_inner = d;
    end else begin
      ctl_rail = 2'b00;
      up_marked = 0; up_eval = 0; dn_marked = 0;
      step();
      chk("R8 no inner_en on drop", inner_en, 0);
      chk("R4 outer held one edge", outer_marked, 1);
      step();
      chk("R4 outer empties on drop", outer_marked, 0);
      chk("R8 no inner token", inner_marked, 0);
      step();
      chk("R5 ctl released after drop", ctl_marked, 0);
      chk("R8 inner data kept", inner_data, last_inner);
    end
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    step(); step();
    rst_n = 1;
    chk("R1 outer_en", outer_en, 0);
    chk("R1 outer_marked", outer_marked, 0);
    chk("R1 ctl_marked", ctl_marked, 0);
    chk("R1 inner_en", inner_en, 0);
    chk("R1 inner_marked", inner_marked, 0);
    chk("R1 inner_data", inner_data, 0);
    chk("R1 ctl_err", ctl_err, 0);

    // R2: evaluation missing keeps the outer side disabled
    up_marked = 1; up_eval = 0;
    step(); step();
    chk("R2 eval missing", outer_en, 0);
    chk("R3 no token when disabled", outer_marked, 0);
    up_marked = 0;
    step();

    for (int d = 0; d < 256; d += 17)
      for (int m = 0; m < 2; m++)
        for (int s = 0; s < 3; s += 2)
          run(d[W-1:0], m[0], s);

    // R3: a full inner side blocks a new outer token
    up_marked = 1; up_eval = 1; up_data = 8'h5a; ctl_rail = 2'b01;
    step(); step(); step(); step(); step();
    chk("R6 fill", inner_marked, 1);
    up_marked = 0; up_eval = 0; ctl_rail = 2'b00;
    step(); step(); step();
    chk("R5 released", ctl_marked, 0);
    up_marked = 1; up_eval = 1; up_data = 8'hc3;
    step(); step(); step();
    chk("R3 blocked by inner", outer_marked, 0);
    dn_marked = 1;
    step();
    chk("R7 drain", inner_marked, 0);
    dn_marked = 0;
    step();
    chk("R3 accepted after drain", outer_marked, 1);

    // R9: illegal rail code
    ctl_rail = 2'b11;
    step();
    chk("R9 err flagged", ctl_err, 1);
    chk("R9 not accepted", ctl_marked, 0);
    ctl_rail = 2'b10;
    step();
    chk("R9 err cleared", ctl_err, 0);
    chk("R5 zero token taken", ctl_marked, 1);
    ctl_rail = 2'b00; up_marked = 0; up_eval = 0;
    step(); step();
    chk("R4 drop empties", outer_marked, 0);
    chk("R8 data kept", inner_data, 8'h5a);
    step();
    chk("R5 ctl free", ctl_marked, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule